// File: doc/BRIEF.md
# Multi-Master I2C Arbitration and Collision Controller

This block is the bus-facing core of an I2C master that shares its bus with other masters. It drives SCL and SDA as open-drain lines: an output enable pulls its line low, and releasing it lets the pull-up take the line high. Each command (start, repeated start, byte write, acknowledge, stop) is played out as a sequence of bit quarters. While it runs, the block compares the level it meant to leave on SDA with the level it reads back.

If the block meant SDA to be high, but reads it low while SCL is high, another master has won the bus. The block then drops both lines at once and goes back to idle. It sets a sticky collision flag and clears whichever request was in flight. A collision during a write also clears the transmit-full flag.

A bus monitor tracks start and stop conditions on the synchronized lines. Software can therefore wait for a free bus before it retries the whole message from a start condition. One interrupt pulse is issued each time a command completes and each time a collision occurs.

Top module: `i2c_arb_master`

## Requirements
- R1: After reset both output enables are 0, `coll_flag`, `irq`, `tx_full` and `cond_pend` are 0, `rx_ack` is 1, `start_seen` and `stop_seen` are 0, and `bus_free` is 1.
- R2: `cmd_start` is accepted only when the block is idle, `bus_free` is 1 and `coll_flag` is 0. The start sequence pulls SDA low while SCL is high and then pulls SCL low. `cond_pend[0]` is 1 while the sequence runs.
- R3: `cmd_write` sends the eight bits of `tx_byte`, most significant bit first, each bit held while SCL is high. A ninth clock follows with SDA released, and its level is stored in `rx_ack`. `tx_full` is 1 from acceptance until the byte ends.
- R4: The repeated start sequence (`cond_pend[1]`), the stop sequence (`cond_pend[2]`) and the one-bit acknowledge sequence (`cond_pend[3]`, driving `ack_level`) each complete with an interrupt and no collision when the bus follows them. The acknowledge bit drives SDA low for `ack_level` 0.
- R5: A collision is detected when SDA is read low while the block intends it high, SCL reads high, and the line has had at least the synchronizer delay to settle. The check covers start, repeated start, every written bit, the acknowledge bit and stop. The ninth (receiver) clock of a write is not checked.
- R6: On a collision, `coll_flag` becomes 1, both output enables drop to 0 in the next cycle, the block returns to idle, and a single interrupt pulse is issued.
- R7: A collision during a byte write clears `tx_full`.
- R8: A collision during a start, repeated start, acknowledge or stop sequence clears that sequence's `cond_pend` bit, leaving `cond_pend` all zero.
- R9: `coll_flag` stays 1 until a `coll_clear` strobe.
- R10: While `coll_flag` is 1, `cmd_start` is ignored: the lines stay released, `cond_pend` stays 0, and no interrupt occurs.
- R11: A falling SDA while SCL is high sets `start_seen` and clears `stop_seen`. A rising SDA while SCL is high does the opposite. `bus_free` is 1 when `stop_seen` is 1 or when both bits are 0.
- R12: `irq` is never high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_start | input | 1 | Request a start condition |
| cmd_rstart | input | 1 | Request a repeated start |
| cmd_write | input | 1 | Request a byte write of `tx_byte` |
| cmd_ack | input | 1 | Request one acknowledge bit at `ack_level` |
| cmd_stop | input | 1 | Request a stop condition |
| tx_byte | input | 8 | Byte to write |
| ack_level | input | 1 | Acknowledge bit level (0 pulls SDA low) |
| coll_clear | input | 1 | Write-one-to-clear strobe for `coll_flag` |
| scl_in | input | 1 | Sampled SCL line level |
| sda_in | input | 1 | Sampled SDA line level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| coll_flag | output | 1 | Sticky collision flag |
| irq | output | 1 | One-cycle event/collision interrupt |
| tx_full | output | 1 | Byte write in progress |
| cond_pend | output | 4 | Pending condition: bit0 start, bit1 repeated start, bit2 stop, bit3 acknowledge |
| rx_ack | output | 1 | SDA level seen on the ninth clock of the last write |
| start_seen | output | 1 | Last bus condition seen was a start |
| stop_seen | output | 1 | Last bus condition seen was a stop |
| bus_free | output | 1 | Bus is idle |

## Verification
The assertions assume that a command arrives only while the block can accept it. Start must come from idle. Repeated start, write, acknowledge and stop must come while the block holds the bus between sequences. The assertions also assume that SCL is never held low by anyone else, since the block does not model clock stretching.

The bench follows these assumptions. It issues each command only after the previous one has raised its interrupt. The competing master it models acts on SDA alone, pulling the line low at a chosen point and later releasing it while SCL is high. Releasing SDA this way also produces the stop condition that frees the bus before each retry.

// File: rtl/i2carb_pkg.sv
package i2carb_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OWN,
        ST_START,
        ST_RSTART,
        ST_WRITE,
        ST_ACK,
        ST_STOP
    } phase_e;

    localparam int PEND_W      = 4;
    localparam int PEND_START  = 0;
    localparam int PEND_RSTART = 1;
    localparam int PEND_STOP   = 2;
    localparam int PEND_ACK    = 3;

    typedef struct packed {
        logic scl_low;
        logic sda_low;
        logic check;
    } drive_t;

    // Line drive and expected-high check for one quarter of a bit slot.
    function automatic drive_t quarter_drive(phase_e ph, logic [1:0] q, logic b);
        drive_t d;
        d = '{scl_low: 1'b0, sda_low: 1'b0, check: 1'b0};
        case (ph)
            ST_OWN: d = '{1'b1, 1'b0, 1'b0};
            ST_START: begin
                case (q)
                    2'd0, 2'd1: d = '{1'b0, 1'b0, 1'b1};
                    2'd2:       d = '{1'b0, 1'b1, 1'b0};
                    default:    d = '{1'b1, 1'b1, 1'b0};
                endcase
            end
            ST_RSTART: begin
                case (q)
                    2'd0:    d = '{1'b1, 1'b0, 1'b0};
                    2'd1:    d = '{1'b0, 1'b0, 1'b1};
                    2'd2:    d = '{1'b0, 1'b1, 1'b0};
                    default: d = '{1'b1, 1'b1, 1'b0};
                endcase
            end
            ST_WRITE, ST_ACK: begin
                case (q)
                    2'd0:    d = '{1'b1, ~b, 1'b0};
                    2'd1:    d = '{1'b0, ~b, 1'b0};
                    2'd2:    d = '{1'b0, ~b, b};
                    default: d = '{1'b1, ~b, 1'b0};
                endcase
            end
            ST_STOP: begin
                case (q)
                    2'd0:    d = '{1'b1, 1'b1, 1'b0};
                    2'd1:    d = '{1'b0, 1'b1, 1'b0};
                    2'd2:    d = '{1'b0, 1'b0, 1'b0};
                    default: d = '{1'b0, 1'b0, 1'b1};
                endcase
            end
            default: d = '{1'b0, 1'b0, 1'b0};
        endcase
        return d;
    endfunction

endpackage

// File: rtl/i2carb_sync.sv
module i2carb_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_line
        logic [STAGES-1:0] sh;
        always_ff @(posedge clk) begin
            if (rst) sh <= '1;
            else     sh <= {sh[STAGES-2:0], d[i]};
        end
        assign q[i] = sh[STAGES-1];
    end
endmodule

// File: rtl/i2carb_busmon.sv
module i2carb_busmon (
    input  logic clk,
    input  logic rst,
    input  logic scl_s,
    input  logic sda_s,
    output logic start_seen,
    output logic stop_seen,
    output logic bus_free
);
    logic scl_p, sda_p;
    logic start_ev, stop_ev;

    assign start_ev = scl_s && scl_p && sda_p && !sda_s;
    assign stop_ev  = scl_s && scl_p && !sda_p && sda_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_p      <= 1'b1;
            sda_p      <= 1'b1;
            start_seen <= 1'b0;
            stop_seen  <= 1'b0;
        end else begin
            scl_p <= scl_s;
            sda_p <= sda_s;
            if (start_ev) begin
                start_seen <= 1'b1;
                stop_seen  <= 1'b0;
            end else if (stop_ev) begin
                start_seen <= 1'b0;
                stop_seen  <= 1'b1;
            end
        end
    end

    assign bus_free = stop_seen || !start_seen;

    AST_SEEN_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(start_seen && stop_seen)); // R11
    AST_FREE_AFTER_STOP: assert property (@(posedge clk) disable iff (rst)
        stop_ev |=> bus_free); // R11
    AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (rst)
        start_ev |=> !bus_free); // R11
endmodule

// File: rtl/i2carb_seq.sv
module i2carb_seq
    import i2carb_pkg::*;
#(
    parameter int QUARTER     = 8,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_start,
    input  logic              req_rstart,
    input  logic              req_write,
    input  logic              req_ack,
    input  logic              req_stop,
    input  logic [DATA_W-1:0] wdata,
    input  logic              ack_lvl,
    input  logic              coll_clr,
    input  logic              scl_s,
    input  logic              sda_s,
    input  logic              bus_free,
    output logic              scl_oe,
    output logic              sda_oe,
    output logic              coll_flag,
    output logic              irq,
    output logic              tx_full,
    output logic [PEND_W-1:0] pend,
    output logic              rx_ack
);
    localparam int CW = (QUARTER > 1) ? $clog2(QUARTER) : 1;
    localparam int BW = $clog2(DATA_W + 2);
    localparam int SW = DATA_W + 1;

    phase_e        st;
    logic [CW-1:0] qcnt;
    logic [1:0]    quarter;
    logic [BW-1:0] bitn;
    logic [SW-1:0] shreg;

    drive_t        drv;
    logic          active;
    logic          quarter_end;
    logic          slot_end;
    logic          op_end;
    logic [BW-1:0] last_idx;
    logic          chk_ok;
    logic          collision;

    assign drv         = quarter_drive(st, quarter, shreg[SW-1]);
    assign active      = (st != ST_IDLE) && (st != ST_OWN);
    assign quarter_end = (qcnt == CW'(QUARTER - 1));
    assign slot_end    = quarter_end && (quarter == 2'd3);
    assign last_idx    = (st == ST_WRITE) ? BW'(DATA_W) : '0;
    assign op_end      = slot_end && (bitn == last_idx);
    assign chk_ok      = !((st == ST_WRITE) && (bitn == BW'(DATA_W)));
    assign collision   = active && drv.check && chk_ok &&
                         (qcnt >= CW'(SYNC_STAGES)) && scl_s && !sda_s;

    assign scl_oe = drv.scl_low;
    assign sda_oe = drv.sda_low;

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            qcnt      <= '0;
            quarter   <= '0;
            bitn      <= '0;
            shreg     <= '1;
            coll_flag <= 1'b0;
            irq       <= 1'b0;
            tx_full   <= 1'b0;
            pend      <= '0;
            rx_ack    <= 1'b1;
        end else begin
            irq <= 1'b0;
            if (coll_clr) coll_flag <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (req_start && !coll_flag && bus_free) begin
                        st               <= ST_START;
                        pend[PEND_START] <= 1'b1;
                        qcnt             <= '0;
                        quarter          <= '0;
                        bitn             <= '0;
                    end
                end
                ST_OWN: begin
                    qcnt    <= '0;
                    quarter <= '0;
                    bitn    <= '0;
                    if (req_rstart) begin
                        st                <= ST_RSTART;
                        pend[PEND_RSTART] <= 1'b1;
                    end else if (req_write) begin
                        st      <= ST_WRITE;
                        tx_full <= 1'b1;
                        shreg   <= {wdata, 1'b1};
                    end else if (req_ack) begin
                        st             <= ST_ACK;
                        pend[PEND_ACK] <= 1'b1;
                        shreg          <= {ack_lvl, {DATA_W{1'b1}}};
                    end else if (req_stop) begin
                        st              <= ST_STOP;
                        pend[PEND_STOP] <= 1'b1;
                    end
                end
                default: begin
                    if (collision) begin
                        st        <= ST_IDLE;
                        coll_flag <= 1'b1;
                        irq       <= 1'b1;
                        pend      <= '0;
                        tx_full   <= 1'b0;
                    end else begin
                        qcnt <= quarter_end ? '0 : qcnt + 1'b1;
                        if (quarter_end) quarter <= quarter + 2'd1;
                        if ((st == ST_WRITE) && (bitn == BW'(DATA_W)) &&
                            (quarter == 2'd2) && quarter_end)
                            rx_ack <= sda_s;
                        if (slot_end) begin
                            bitn  <= bitn + 1'b1;
                            shreg <= {shreg[SW-2:0], 1'b1};
                        end
                        if (op_end) begin
                            irq     <= 1'b1;
                            pend    <= '0;
                            tx_full <= 1'b0;
                            st      <= (st == ST_STOP) ? ST_IDLE : ST_OWN;
                        end
                    end
                end
            endcase
        end
    end

    AST_COLL_RELEASE: assert property (@(posedge clk) disable iff (rst)
        collision |=> (!scl_oe && !sda_oe && coll_flag)); // R6
    AST_COLL_IRQ: assert property (@(posedge clk) disable iff (rst)
        collision |=> irq); // R6
    AST_COLL_TXFULL: assert property (@(posedge clk) disable iff (rst)
        (collision && st == ST_WRITE) |=> !tx_full); // R7
    AST_COLL_PEND: assert property (@(posedge clk) disable iff (rst)
        collision |=> (pend == '0)); // R8
    AST_COLL_STICKY: assert property (@(posedge clk) disable iff (rst)
        (coll_flag && !coll_clr) |=> coll_flag); // R9
    AST_NO_START_LOCKED: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && coll_flag) |=> (!scl_oe && !sda_oe)); // R10
    AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq); // R12
    AST_PEND_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(pend)); // R8
endmodule

// File: rtl/i2c_arb_master.sv
module i2c_arb_master
    import i2carb_pkg::*;
#(
    parameter int QUARTER     = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cmd_start,
    input  logic       cmd_rstart,
    input  logic       cmd_write,
    input  logic       cmd_ack,
    input  logic       cmd_stop,
    input  logic [7:0] tx_byte,
    input  logic       ack_level,
    input  logic       coll_clear,
    input  logic       scl_in,
    input  logic       sda_in,
    output logic       scl_oe,
    output logic       sda_oe,
    output logic       coll_flag,
    output logic       irq,
    output logic       tx_full,
    output logic [3:0] cond_pend,
    output logic       rx_ack,
    output logic       start_seen,
    output logic       stop_seen,
    output logic       bus_free
);
    logic scl_s, sda_s;

    initial begin
        AST_QUARTER_LEN: assert (QUARTER > SYNC_STAGES + 1); // R5
    end

    i2carb_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({scl_in, sda_in}),
        .q   ({scl_s, sda_s})
    );

    i2carb_busmon u_mon (
        .clk        (clk),
        .rst        (rst),
        .scl_s      (scl_s),
        .sda_s      (sda_s),
        .start_seen (start_seen),
        .stop_seen  (stop_seen),
        .bus_free   (bus_free)
    );

    i2carb_seq #(
        .QUARTER     (QUARTER),
        .DATA_W      (8),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .req_start  (cmd_start),
        .req_rstart (cmd_rstart),
        .req_write  (cmd_write),
        .req_ack    (cmd_ack),
        .req_stop   (cmd_stop),
        .wdata      (tx_byte),
        .ack_lvl    (ack_level),
        .coll_clr   (coll_clear),
        .scl_s      (scl_s),
        .sda_s      (sda_s),
        .bus_free   (bus_free),
        .scl_oe     (scl_oe),
        .sda_oe     (sda_oe),
        .coll_flag  (coll_flag),
        .irq        (irq),
        .tx_full    (tx_full),
        .pend       (cond_pend),
        .rx_ack     (rx_ack)
    );
endmodule

// File: tb/sim_i2c_arb_master.sv
module sim_i2c_arb_master;
    localparam int Q = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cmd_start = 0, cmd_rstart = 0, cmd_write = 0, cmd_ack = 0, cmd_stop = 0;
    logic [7:0] tx_byte = 8'h00;
    logic ack_level = 1'b1;
    logic coll_clear = 1'b0;
    logic other_sda = 1'b0;
    logic scl_in, sda_in;
    logic scl_oe, sda_oe, coll_flag, irq, tx_full, rx_ack;
    logic start_seen, stop_seen, bus_free;
    logic [3:0] cond_pend;

    assign scl_in = !scl_oe;
    assign sda_in = !(sda_oe || other_sda);

    always #10 clk = ~clk;

    i2c_arb_master #(.QUARTER(Q)) u0 (
        .clk(clk), .rst(rst), .cmd_start(cmd_start), .cmd_rstart(cmd_rstart),
        .cmd_write(cmd_write), .cmd_ack(cmd_ack), .cmd_stop(cmd_stop),
        .tx_byte(tx_byte), .ack_level(ack_level), .coll_clear(coll_clear),
        .scl_in(scl_in), .sda_in(sda_in), .scl_oe(scl_oe), .sda_oe(sda_oe),
        .coll_flag(coll_flag), .irq(irq), .tx_full(tx_full), .cond_pend(cond_pend),
        .rx_ack(rx_ack), .start_seen(start_seen), .stop_seen(stop_seen),
        .bus_free(bus_free)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // kind: 0 start, 1 rstart, 2 write, 3 ack, 4 stop
    typedef struct {
        int         kind;
        logic       coll;
        logic [7:0] data;
    } exp_t;
    exp_t sb[$];

    logic [8:0] cap = '1;
    always @(posedge scl_in) cap = {cap[7:0], sda_in};

    logic prev_irq = 1'b0;
    always @(negedge clk) begin
        if (!rst) begin
            if (prev_irq) chk(irq == 1'b0, "R12 irq single cycle", irq, 0);
            if (irq) begin
                if (sb.size() == 0) begin
                    chk(1'b0, "R10 unexpected irq", 1, 0);
                end else begin
                    exp_t it;
                    it = sb.pop_front();
                    chk(coll_flag == it.coll, it.coll ? "R5 collision detected" : "R4 event done clean",
                        coll_flag, it.coll);
                    chk(cond_pend == 4'b0, "R8 pending cleared", cond_pend, 0);
                    if (it.kind == 2)
                        chk(tx_full == 1'b0, "R7 tx_full cleared", tx_full, 0);
                    if (it.coll)
                        chk(!scl_oe && !sda_oe, "R6 lines released", {scl_oe, sda_oe}, 0);
                    if (it.kind == 2 && !it.coll) begin
                        chk(cap[8:1] == it.data, "R3 byte on bus", cap[8:1], it.data);
                        chk(rx_ack == 1'b1, "R3 ninth clock level", rx_ack, 1);
                    end
                    if (it.kind == 4 && !it.coll)
                        chk(bus_free && stop_seen, "R11 free after stop", {bus_free, stop_seen}, 2'b11);
                end
            end
            prev_irq <= irq;
        end
    end

    task automatic send(input int kind, input logic [7:0] data, input logic lvl,
                        input logic coll);
        exp_t it;
        it.kind = kind; it.coll = coll; it.data = data;
        sb.push_back(it);
        @(negedge clk);
        tx_byte   = data;
        ack_level = lvl;
        case (kind)
            0: cmd_start = 1;
            1: cmd_rstart = 1;
            2: cmd_write = 1;
            3: cmd_ack = 1;
            default: cmd_stop = 1;
        endcase
        @(negedge clk);
        cmd_start = 0; cmd_rstart = 0; cmd_write = 0; cmd_ack = 0; cmd_stop = 0;
    endtask

    task automatic wait_done();
        while (sb.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic clear_coll();
        @(negedge clk); coll_clear = 1;
        @(negedge clk); coll_clear = 0;
    endtask

    task automatic other_release();
        @(negedge clk); other_sda = 0;
        repeat (6) @(negedge clk);
    endtask

    initial begin
        int wd = 0;
        forever begin
            @(posedge clk);
            wd++;
            if (wd > 150000) begin
                errors++;
                checks++;
                $display("FAIL watchdog expired");
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk(!scl_oe && !sda_oe, "R1 lines released", {scl_oe, sda_oe}, 0);
        chk(!coll_flag && !irq && !tx_full && cond_pend == 0, "R1 flags clear",
            {coll_flag, irq, tx_full, cond_pend}, 0);
        chk(rx_ack && bus_free && !start_seen && !stop_seen, "R1 monitor reset",
            {rx_ack, bus_free, start_seen, stop_seen}, 4'b1100);

        // R2 clean start
        send(0, 8'h00, 1, 0);
        repeat (3) @(negedge clk);
        chk(cond_pend == 4'b0001, "R2 start pending", cond_pend, 1);
        wait_done();
        chk(start_seen && !bus_free, "R11 start seen", {start_seen, bus_free}, 2'b10);
        chk(scl_oe, "R2 holds SCL low", scl_oe, 1);

        // R3 writes
        send(2, 8'hA5, 1, 0);
        repeat (3) @(negedge clk);
        chk(tx_full, "R3 tx_full while writing", tx_full, 1);
        wait_done();
        send(2, 8'h3C, 1, 0);
        wait_done();

        // R4 ack, repeated start, stop
        send(3, 8'h00, 0, 0);
        wait_done();
        send(1, 8'h00, 1, 0);
        wait_done();
        send(4, 8'h00, 1, 0);
        wait_done();
        chk(!scl_oe && !sda_oe, "R4 idle after stop", {scl_oe, sda_oe}, 0);

        // R5/R7 collision in a byte write
        send(0, 8'h00, 1, 0);
        wait_done();
        @(negedge clk); other_sda = 1;
        send(2, 8'hFF, 1, 1);
        wait_done();
        chk(coll_flag, "R6 flag set", coll_flag, 1);
        other_release();
        chk(bus_free && stop_seen, "R11 other master stop", {bus_free, stop_seen}, 2'b11);

        // R10 start ignored while flag set
        @(negedge clk); cmd_start = 1;
        @(negedge clk); cmd_start = 0;
        repeat (4*Q) @(negedge clk);
        chk(!scl_oe && !sda_oe && cond_pend == 0, "R10 start ignored",
            {scl_oe, sda_oe, cond_pend}, 0);
        chk(coll_flag, "R9 flag sticky", coll_flag, 1);
        clear_coll();
        chk(!coll_flag, "R9 flag cleared", coll_flag, 0);

        // R5/R8 collision during start
        send(0, 8'h00, 1, 1);
        repeat (Q + 1) @(negedge clk);
        other_sda = 1;
        wait_done();
        other_release();
        clear_coll();

        // collision during repeated start
        send(0, 8'h00, 1, 0);
        wait_done();
        send(1, 8'h00, 1, 1);
        repeat (Q + 1) @(negedge clk);
        other_sda = 1;
        wait_done();
        other_release();
        clear_coll();

        // collision during acknowledge (released level)
        send(0, 8'h00, 1, 0);
        wait_done();
        send(3, 8'h00, 1, 1);
        other_sda = 1;
        wait_done();
        other_release();
        clear_coll();

        // collision during stop
        send(0, 8'h00, 1, 0);
        wait_done();
        send(4, 8'h00, 1, 1);
        other_sda = 1;
        wait_done();
        other_release();
        chk(bus_free, "R11 free after release", bus_free, 1);
        clear_coll();

        // retry works after clearing
        send(0, 8'h00, 1, 0);
        wait_done();
        send(4, 8'h00, 1, 0);
        wait_done();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule